// File: doc/BRIEF.md
# Multi-Cycle Latch Input Qualifier

This block sits between the digital comparator on the protection pin and the fault sequencer of a switching power controller. That pin senses over-voltage and over-temperature events, and its comparator trips at 3.0 V. The pin also carries other signals while the power switch conducts. For that reason the qualifier reads the comparator flag only in a window after each driver turn-off. That window opens after a blanking interval and closes when the driver turns on again.

Within the window the flag must hold high for a run of consecutive clock samples before the switching cycle counts as faulty. The qualifier counts faulty switching cycles. A cycle with no qualified fault sets the count back to zero. When the count reaches the confirmation number, the block issues a one-clock request to the fault sequencer. An option input decides whether that request is a latch request or an auto-recovery request. All times are in system clock cycles and are set by parameters: `BLANK_CYC` (about 1 µs), `FILT_CYC` (about 600 ns) and `CONFIRM` (4 cycles).

Top module: `latch_input_qualifier`

## Requirements
- R1: While `rst_ni` is low, both request outputs are 0.
- R2: A driver turn-off is detected at the first clock edge that samples `drv_pulse_i` low after it was high. The flag is ignored on that edge and on the `BLANK_CYC` edges that follow it.
- R3: A switching cycle is faulty only if the flag is sampled high on `FILT_CYC` consecutive edges inside the window. A shorter run of high samples leaves the cycle clean.
- R4: A switching cycle ends at the edge that detects turn-on, which is the first edge that samples `drv_pulse_i` high after it was low. If that cycle is the `CONFIRM`-th faulty cycle in a row, one request is asserted for exactly one clock, registered at that edge. At no other time is a request asserted.
- R5: A cycle that ends clean sets the consecutive count to zero, so faulty cycles on both sides of it do not add together.
- R6: When `auto_mode_i` is 1 at the ending edge, the request appears on `recover_req_o` and never on `latch_req_o`. When `auto_mode_i` is 0, the request appears on `latch_req_o` and never on `recover_req_o`.
- R7: While `drv_en_i` is low, the count and the window state are cleared and both outputs are 0. A cycle that is still open when the driver is disabled never counts.
- R8: After a request the count restarts at zero, so the next request needs `CONFIRM` new faulty cycles.
- R9: The flag is not sampled on the turn-on edge or during on-time, so a high level during on-time adds nothing to the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drv_en_i | input | 1 | Driver enabled; low clears all qualification state |
| drv_pulse_i | input | 1 | Driver gate command, high during on-time |
| trip_flag_i | input | 1 | Comparator result from the protection pin, high above trip level |
| auto_mode_i | input | 1 | Option select: 1 auto-recovery, 0 latch |
| latch_req_o | output | 1 | One-clock latch request to the fault sequencer |
| recover_req_o | output | 1 | One-clock auto-recovery request to the fault sequencer |

## Verification
Suppose the consecutive count holds a stale value, for example because a clean cycle failed to clear it. A request would then appear at the turn-on edge of a cycle that is too early, and the error would show within one switching period of the bad update. If the blanking timer or the persistence run is off by one, a cycle whose flag sits exactly on the window boundary is judged wrong. That error shows at the fourth such cycle, as a missing or extra request. A fault in option routing shows on the very first confirmed request, because it arrives on the wrong output.

// File: rtl/lq_pkg.sv
package lq_pkg;
  // Window phase within one switching period
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // waiting for a driver turn-off
    PH_BLANK = 2'd1,  // blanking after turn-off, flag ignored
    PH_WATCH = 2'd2   // flag observed until the next turn-on
  } phase_e;
endpackage

// File: rtl/lq_edge.sv
module lq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drv_pulse_i,
  output logic turn_off_o,
  output logic turn_on_o
);
  logic drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= 1'b0;
    else         drv_q <= drv_pulse_i;
  end

  assign turn_off_o = drv_q & ~drv_pulse_i;
  assign turn_on_o  = ~drv_q & drv_pulse_i;
endmodule

// File: rtl/lq_window.sv
module lq_window
  import lq_pkg::*;
#(
  parameter int BLANK_CYC = 8,
  parameter int FILT_CYC  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drv_en_i,
  input  logic turn_off_i,
  input  logic turn_on_i,
  input  logic trip_flag_i,
  output logic cyc_done_o,
  output logic cyc_bad_o
);
  localparam int TW = (BLANK_CYC > 1) ? $clog2(BLANK_CYC) : 1;
  localparam int RW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [TW-1:0] TMR_LAST = TW'(BLANK_CYC - 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(FILT_CYC - 1);

  phase_e          phase;
  logic [TW-1:0]   tmr;
  logic [RW-1:0]   run;
  logic            hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase <= PH_IDLE;
      tmr   <= '0;
      run   <= '0;
      hit   <= 1'b0;
    end else if (!drv_en_i) begin
      phase <= PH_IDLE;
      tmr   <= '0;
      run   <= '0;
      hit   <= 1'b0;
    end else if (turn_off_i) begin
      phase <= PH_BLANK;
      tmr   <= '0;
      run   <= '0;
      hit   <= 1'b0;
    end else if (turn_on_i) begin
      phase <= PH_IDLE;
      run   <= '0;
      hit   <= 1'b0;
    end else begin
      unique case (phase)
        PH_BLANK: begin
          if (tmr == TMR_LAST) phase <= PH_WATCH;
          else                 tmr   <= tmr + 1'b1;
        end
        PH_WATCH: begin
          if (trip_flag_i) begin
            if (run == RUN_LAST) hit <= 1'b1;
            else                 run <= run + 1'b1;
          end else begin
            run <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign cyc_done_o = drv_en_i & turn_on_i & (phase != PH_IDLE);
  assign cyc_bad_o  = hit;

  // R2: no fault can be qualified while the blanking interval runs
  p_blank_no_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_BLANK) |=> !$rose(hit));
  // R3: a qualified fault needs the flag high on the edge that completes the run
  p_hit_needs_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit) |-> $past(trip_flag_i));
endmodule

// File: rtl/lq_confirm.sv
module lq_confirm #(
  parameter int CONFIRM = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drv_en_i,
  input  logic cyc_done_i,
  input  logic cyc_bad_i,
  input  logic auto_mode_i,
  output logic latch_req_o,
  output logic recover_req_o
);
  localparam int CW = (CONFIRM > 1) ? $clog2(CONFIRM) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CONFIRM - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt           <= '0;
      latch_req_o   <= 1'b0;
      recover_req_o <= 1'b0;
    end else if (!drv_en_i) begin
      cnt           <= '0;
      latch_req_o   <= 1'b0;
      recover_req_o <= 1'b0;
    end else begin
      latch_req_o   <= 1'b0;
      recover_req_o <= 1'b0;
      if (cyc_done_i) begin
        if (cyc_bad_i) begin
          if (cnt == CNT_LAST) begin
            cnt           <= '0;
            latch_req_o   <= ~auto_mode_i;
            recover_req_o <= auto_mode_i;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end
    end
  end

  // R5: a clean cycle end leaves the count at zero
  p_clean_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_i && cyc_done_i && !cyc_bad_i) |=> (cnt == '0));
  // R6: option routing of the request
  p_recover_option_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_req_o |-> $past(auto_mode_i));
  p_latch_option_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_req_o |-> !$past(auto_mode_i));
  // R7: a disabled driver yields no request
  p_disabled_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_en_i |=> (!latch_req_o && !recover_req_o));
  // R4: a request is one clock long
  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_req_o || recover_req_o) |=> (!latch_req_o && !recover_req_o));
endmodule

// File: rtl/latch_input_qualifier.sv
module latch_input_qualifier #(
  parameter int BLANK_CYC = 8,
  parameter int FILT_CYC  = 4,
  parameter int CONFIRM   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drv_en_i,
  input  logic drv_pulse_i,
  input  logic trip_flag_i,
  input  logic auto_mode_i,
  output logic latch_req_o,
  output logic recover_req_o
);
  logic turn_off, turn_on, cyc_done, cyc_bad;

  lq_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drv_pulse_i (drv_pulse_i),
    .turn_off_o  (turn_off),
    .turn_on_o   (turn_on)
  );

  lq_window #(.BLANK_CYC(BLANK_CYC), .FILT_CYC(FILT_CYC)) u_window (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drv_en_i    (drv_en_i),
    .turn_off_i  (turn_off),
    .turn_on_i   (turn_on),
    .trip_flag_i (trip_flag_i),
    .cyc_done_o  (cyc_done),
    .cyc_bad_o   (cyc_bad)
  );

  lq_confirm #(.CONFIRM(CONFIRM)) u_confirm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .drv_en_i      (drv_en_i),
    .cyc_done_i    (cyc_done),
    .cyc_bad_i     (cyc_bad),
    .auto_mode_i   (auto_mode_i),
    .latch_req_o   (latch_req_o),
    .recover_req_o (recover_req_o)
  );

  // R4: requests only follow an enabled turn-on edge
  p_req_at_turn_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_req_o || recover_req_o) |-> ($past(turn_on) && $past(drv_en_i)));
endmodule

// File: tb/test_latch_input_qualifier.sv
module test_latch_input_qualifier;
  localparam int CLK_P   = 10;
  localparam int BLANK   = 8;
  localparam int FILT    = 4;
  localparam int CONF    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, drv = 1'b0, flag = 1'b0, auto_m = 1'b0;
  logic latch_req, recover_req;

  int n_cmp = 0, n_bad = 0;
  int model_cnt = 0;
  bit due = 0;
  bit mon_on = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  latch_input_qualifier #(.BLANK_CYC(BLANK), .FILT_CYC(FILT), .CONFIRM(CONF)) i_latch_input_qualifier (
    .clk_i(clk), .rst_ni(rst_n), .drv_en_i(en), .drv_pulse_i(drv),
    .trip_flag_i(flag), .auto_mode_i(auto_m),
    .latch_req_o(latch_req), .recover_req_o(recover_req)
  );

  task automatic chk(input logic [1:0] got, input logic [1:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {latch,recover} got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // Monitor: every clock, a quarter period after the edge
  initial forever begin
    @(posedge clk);
    #(CLK_P/4);
    if (mon_on) begin
      if (due) begin
        chk({latch_req, recover_req}, exp_q.pop_front(), tag_q.pop_front());
        due = 0;
      end else begin
        chk({latch_req, recover_req}, 2'b00, "R4 no request outside a turn-on edge");
      end
    end
  end

  // One switching period: off edges 0..off-1, turn-on edge at index off.
  // Flag is high on edges s..s+len-1 (index counted from the turn-off edge).
  task automatic sw_cycle(input int off, input int on, input int s, input int len, input string tag);
    int runv = 0;
    bit faulty = 0;
    logic [1:0] e;
    for (int j = BLANK + 1; j < off; j++) begin
      if (j >= s && j < s + len) runv++; else runv = 0;
      if (runv >= FILT) faulty = 1;
    end
    for (int i = 0; i < off + on; i++) begin
      @(negedge clk);
      drv  = (i >= off);
      flag = (i >= s && i < s + len);
      if (i == off) begin
        e = 2'b00;
        if (faulty) begin
          model_cnt++;
          if (model_cnt == CONF) begin
            e = auto_m ? 2'b01 : 2'b10;
            model_cnt = 0;
          end
        end else begin
          model_cnt = 0;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        due = 1;
      end
    end
  endtask

  task automatic disable_drv(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); en = 0; drv = 0; flag = 0;
    end
    model_cnt = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); en = 1; drv = 1;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset holds outputs low even with stimulus active
    en = 1; drv = 1; flag = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      drv = ~drv;
      chk({latch_req, recover_req}, 2'b00, "R1 reset");
    end
    @(negedge clk); drv = 1; flag = 0; rst_n = 1;
    @(negedge clk); @(negedge clk);
    mon_on = 1;

    // R4 + R6: four faulty cycles in latch option
    for (int k = 0; k < 4; k++) sw_cycle(20, 6, 10, 6, "R4 R6 latch on 4th faulty cycle");
    // R8: count restarts after a request
    for (int k = 0; k < 4; k++) sw_cycle(20, 6, 10, 6, "R8 second request after 4 new cycles");
    // R2: flag only inside blanking
    for (int k = 0; k < 5; k++) sw_cycle(20, 6, 0, 9, "R2 blanking ignored");
    // R2 boundary: only 3 samples past blanking -> clean
    for (int k = 0; k < 4; k++) sw_cycle(20, 6, 6, 6, "R2 boundary 3 samples clean");
    // R2 boundary: exactly 4 samples past blanking -> faulty
    for (int k = 0; k < 4; k++) sw_cycle(20, 6, 6, 7, "R2 R3 boundary 4 samples faulty");
    // R3: run shorter than the filter
    for (int k = 0; k < 5; k++) sw_cycle(20, 6, 10, 3, "R3 short run clean");
    // R5: a clean cycle in between breaks the sequence
    for (int k = 0; k < 3; k++) sw_cycle(20, 6, 10, 6, "R5 before clean cycle");
    sw_cycle(20, 6, 0, 0, "R5 clean cycle");
    for (int k = 0; k < 3; k++) sw_cycle(20, 6, 10, 6, "R5 after clean cycle");
    sw_cycle(20, 6, 10, 6, "R5 fourth in a row after clean");
    // R9: high level spilling into on-time does not extend the run
    for (int k = 0; k < 5; k++) sw_cycle(20, 6, 17, 20, "R9 on-time flag ignored");
    // R6: auto-recovery option
    @(negedge clk); auto_m = 1;
    for (int k = 0; k < 4; k++) sw_cycle(20, 6, 10, 6, "R6 auto-recovery request");
    // R7: disable clears the count
    for (int k = 0; k < 3; k++) sw_cycle(20, 6, 10, 6, "R7 before disable");
    disable_drv(5);
    sw_cycle(20, 6, 10, 6, "R7 count cleared by disable");
    for (int k = 0; k < 3; k++) sw_cycle(20, 6, 10, 6, "R7 request after re-enable");
    // R7: disable in the middle of an open window
    @(negedge clk); auto_m = 0;
    for (int k = 0; k < 3; k++) sw_cycle(20, 6, 10, 6, "R7 pre mid-window disable");
    for (int i = 0; i < 14; i++) begin
      @(negedge clk); drv = 0; flag = (i >= 10);
    end
    disable_drv(4);
    for (int k = 0; k < 4; k++) sw_cycle(20, 6, 10, 6, "R7 open window never counted");

    @(negedge clk); @(negedge clk);
    mon_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule